// File: doc/BRIEF.md
# One-Wire Slave Presence Responder and Write-Slot Byte Receiver

This block is the receive side of a slave on a single-conductor open-drain bus. It watches a bus line that has already been synchronised to the core clock, and it keeps time with a one-microsecond strobe. A low period long enough to count as a bus reset is recognised when the line returns high. The block then waits a fixed delay, pulls the line low for a fixed time to announce itself, and releases the line again. It touches the bus only through an open-drain pull-down enable, and the external pull-up restores the high level.

Outside a reset, every falling edge starts a write slot. The line is sampled a fixed number of microseconds after that edge. A high sample is a 1 bit and is taken at once. A low sample is held as a pending 0 until the line rises again, so that a low period that turns into a reset never gets into the data. Bits fill a byte least significant bit first. When eight bits have arrived, the byte is shown on a data output together with a one-cycle valid strobe. A reset throws away any partly received byte.

Top module: `ow_slave_rx`

## Requirements
- R1: A low period of at least RESET_US (default 480) microsecond ticks, ended by a rising edge, is taken as a reset. It starts the presence response and does not produce a data bit.
- R2: After the rising edge that ends a reset, drive_low_o asserts after a delay of PRES_WAIT_US (default 30) ticks. This delay stays within 15 to 60 microseconds.
- R3: drive_low_o then stays asserted for PRES_LEN_US (default 120) ticks, within 60 to 240 microseconds, and is then released.
- R4: A falling edge outside a presence response opens a write slot. SAMPLE_US (default 30) ticks later the line is sampled: a high line gives bit value 1, a low line gives bit value 0.
- R5: A low period shorter than RESET_US ticks gives a single 0 bit and no presence response. A 479-tick low period is the limit case.
- R6: Bits are assembled least significant first. byte_data_o bit 0 holds the first bit received in the byte, and bit 7 holds the eighth.
- R7: byte_valid_o pulses high for exactly one clock cycle after every eighth bit, and byte_data_o holds that byte.
- R8: A reset clears the partial byte and the bit counter, so the next eight bits form a complete new byte.
- R9: The falling and rising edges caused by the block's own presence pulse produce no bit, no byte and no further reset.
- R10: While rst_ni is low, drive_low_o and byte_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, once per microsecond |
| line_i | input | 1 | Synchronised bus level (1 = high) |
| drive_low_o | output | 1 | Open-drain enable: 1 pulls the bus low |
| byte_valid_o | output | 1 | One-cycle strobe when a byte is complete |
| byte_data_o | output | 8 | Last completed byte, first bit in bit 0 |

## Verification
The checker monitors on every cycle that the valid strobe lasts one cycle, that the presence pulse never goes past 240 ticks and always reaches 60 ticks, that the pulse starts only from a released line, that no byte comes out while the block is pulling the bus, and what the outputs hold during reset. The bench scenarios have to show the rest: the decoded bit values and their order, the boundary at 479 and 480 low ticks, that a partial byte is thrown away on reset, and the delay from the end of a reset to the presence pulse. They drive a modelled master and a wired-AND pull-up with random bytes and with directed edge cases.

// File: rtl/ow_rx_pkg.sv
package ow_rx_pkg;
  typedef enum logic [1:0] {
    PR_IDLE  = 2'd0,
    PR_WAIT  = 2'd1,
    PR_DRIVE = 2'd2,
    PR_GUARD = 2'd3
  } pres_state_e;
endpackage

// File: rtl/ow_line_mon.sv
module ow_line_mon #(
  parameter int RESET_US = 480,
  parameter int LOW_W    = $clog2(RESET_US + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  output logic             fall_o,
  output logic             rise_o,
  output logic [LOW_W-1:0] low_cnt_o
);
  localparam logic [LOW_W-1:0] SAT = LOW_W'(RESET_US);

  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q    <= 1'b1;
      low_cnt_o <= '0;
    end else if (tick_i) begin
      line_q <= line_i;
      if (line_i)               low_cnt_o <= '0;
      else if (low_cnt_o != SAT) low_cnt_o <= low_cnt_o + 1'b1;
    end
  end

  assign fall_o = tick_i & line_q & ~line_i;
  assign rise_o = tick_i & ~line_q & line_i;
endmodule

// File: rtl/ow_presence_gen.sv
module ow_presence_gen
  import ow_rx_pkg::*;
#(
  parameter int WAIT_US = 30,
  parameter int LEN_US  = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic busy_o,
  output logic drive_o
);
  localparam int MAXV = (WAIT_US > LEN_US) ? WAIT_US : LEN_US;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] WAIT_END = CW'(WAIT_US - 1);
  localparam logic [CW-1:0] LEN_END  = CW'(LEN_US - 1);

  pres_state_e state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PR_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PR_IDLE: if (start_i) begin
          state_q <= PR_WAIT;
          cnt_q   <= '0;
        end
        PR_WAIT: if (tick_i) begin
          if (cnt_q == WAIT_END) begin
            state_q <= PR_DRIVE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PR_DRIVE: if (tick_i) begin
          if (cnt_q == LEN_END) state_q <= PR_GUARD;
          else                  cnt_q   <= cnt_q + 1'b1;
        end
        // one tick to absorb the rising edge of our own release
        PR_GUARD: if (tick_i) state_q <= PR_IDLE;
        default:  state_q <= PR_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != PR_IDLE);
  assign drive_o = (state_q == PR_DRIVE);
endmodule

// File: rtl/ow_slot_decoder.sv
module ow_slot_decoder #(
  parameter int SAMPLE_US = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic fall_i,
  input  logic rise_i,
  input  logic reset_i,
  output logic bit_vld_o,
  output logic bit_o
);
  localparam int CW = $clog2(SAMPLE_US + 1);
  localparam logic [CW-1:0] SAMPLE_AT = CW'(SAMPLE_US);

  logic          slot_act_q;
  logic [CW-1:0] slot_cnt_q;
  logic          pend0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_act_q <= 1'b0;
      slot_cnt_q <= '0;
      pend0_q    <= 1'b0;
      bit_vld_o  <= 1'b0;
      bit_o      <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (fall_i) begin
        slot_act_q <= 1'b1;
        slot_cnt_q <= CW'(1);
      end else if (tick_i && slot_act_q) begin
        if (slot_cnt_q == SAMPLE_AT) begin
          slot_act_q <= 1'b0;
          if (line_i) begin
            bit_vld_o <= 1'b1;
            bit_o     <= 1'b1;
          end else begin
            pend0_q <= 1'b1;  // commit only once the low period proves short
          end
        end else begin
          slot_cnt_q <= slot_cnt_q + 1'b1;
        end
      end
      if (rise_i && pend0_q) begin
        pend0_q <= 1'b0;
        if (!reset_i) begin
          bit_vld_o <= 1'b1;
          bit_o     <= 1'b0;
        end
      end
      if (reset_i) slot_act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ow_byte_asm.sv
module ow_byte_asm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] shreg_nx;

  assign shreg_nx = {bit_i, shreg_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        shreg_q <= '0;
        cnt_q   <= '0;
      end else if (bit_vld_i) begin
        shreg_q <= shreg_nx;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          valid_o <= 1'b1;
          data_o  <= shreg_nx;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ow_slave_rx.sv
module ow_slave_rx #(
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LEN_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int BYTE_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              drive_low_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o
);
  localparam int LOW_W = $clog2(RESET_US + 1);
  localparam logic [LOW_W-1:0] RESET_C = LOW_W'(RESET_US);

  logic             fall, rise, fall_g, rise_g, busy, reset_det;
  logic [LOW_W-1:0] low_cnt;
  logic             bit_vld, bit_val;

  ow_line_mon #(.RESET_US(RESET_US), .LOW_W(LOW_W)) u_mon (
    .clk_i, .rst_ni, .tick_i, .line_i,
    .fall_o(fall), .rise_o(rise), .low_cnt_o(low_cnt)
  );

  // edges during our own presence response are not the master's
  assign fall_g    = fall & ~busy;
  assign rise_g    = rise & ~busy;
  assign reset_det = rise_g & (low_cnt >= RESET_C);

  ow_presence_gen #(.WAIT_US(PRES_WAIT_US), .LEN_US(PRES_LEN_US)) u_pres (
    .clk_i, .rst_ni, .tick_i, .start_i(reset_det),
    .busy_o(busy), .drive_o(drive_low_o)
  );

  ow_slot_decoder #(.SAMPLE_US(SAMPLE_US)) u_dec (
    .clk_i, .rst_ni, .tick_i, .line_i,
    .fall_i(fall_g), .rise_i(rise_g), .reset_i(reset_det),
    .bit_vld_o(bit_vld), .bit_o(bit_val)
  );

  ow_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk_i, .rst_ni, .clr_i(reset_det),
    .bit_vld_i(bit_vld), .bit_i(bit_val),
    .valid_o(byte_valid_o), .data_o(byte_data_o)
  );
endmodule

// File: rtl/ow_slave_rx_chk.sv
module ow_slave_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic line_i,
  input logic drive_low_o,
  input logic byte_valid_o
);
  localparam int PRES_MIN = 60;
  localparam int PRES_MAX = 240;

  logic [8:0] drv_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   drv_ticks <= '0;
    else if (!drive_low_o)         drv_ticks <= '0;
    else if (tick_i)               drv_ticks <= drv_ticks + 1'b1;
  end

  // R7
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  // R3
  pres_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_low_o && tick_i) |-> (drv_ticks < 9'(PRES_MAX)));

  // R3
  pres_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_low_o) |-> (drv_ticks >= 9'(PRES_MIN)));

  // R2
  pres_from_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_low_o) |-> $past(line_i));

  // R9
  no_byte_in_pres_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_low_o |-> !byte_valid_o);

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_out_chk: assert (!drive_low_o && !byte_valid_o);
    end
  end
endmodule

bind ow_slave_rx ow_slave_rx_chk u_chk (.*);

// File: tb/ow_slave_rx_test.sv
`timescale 1ns/1ps
module ow_slave_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       m_low = 1'b0;
  logic       bus;
  logic       drv;
  logic       bvld;
  logic [7:0] bdat;

  int n_chk = 0, n_fail = 0;
  int div = 0;
  logic [7:0] cap [0:63];
  int ncap = 0;
  int drv_rises = 0;
  logic prev_vld = 1'b0, prev_drv = 1'b0;

  always #5 clk = ~clk;

  assign bus = ~(m_low | drv);

  ow_slave_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .line_i(bus),
    .drive_low_o(drv), .byte_valid_o(bvld), .byte_data_o(bdat)
  );

  always @(negedge clk) begin
    div  <= (div == 3) ? 0 : div + 1;
    tick <= (div == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bvld) begin
        if (ncap < 64) cap[ncap] = bdat;
        ncap++;
        if (prev_vld) chk(1'b0, "R7 valid width", 2, 1);
      end
      if (drv && !prev_drv) drv_rises++;
    end
    prev_vld = bvld;
    prev_drv = drv;
  end

  task automatic wait_us(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
      @(negedge clk);
    end
  endtask

  task automatic write_bit(input bit b);
    m_low = 1'b1;
    if (b) begin wait_us(5);  m_low = 1'b0; wait_us(65); end
    else   begin wait_us(65); m_low = 1'b0; wait_us(5);  end
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  function automatic logic [7:0] lsb_first(input logic [7:0] bits_in_order);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = bits_in_order[i];
    return r;
  endfunction

  function automatic bit in_range(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic bus_reset(input int len);
    int w, l;
    m_low = 1'b1;
    wait_us(len);
    m_low = 1'b0;
    w = 0;
    while (!drv && w < 300) begin wait_us(1); w++; end
    chk(in_range(w, 15, 60), "R2 presence delay", w, 31);
    l = 0;
    while (drv && l < 400) begin wait_us(1); l++; end
    chk(in_range(l, 60, 240), "R3 presence length", l, 120);
    chk(bus === 1'b1, "R3 bus released", int'(bus), 1);
    wait_us(10);
  endtask

  task automatic expect_byte(input logic [7:0] exp, input int idx, input string req);
    chk(ncap == idx + 1, {req, " byte count"}, ncap, idx + 1);
    if (ncap == idx + 1) chk(cap[idx] == exp, {req, " byte data"}, int'(cap[idx]), int'(exp));
  endtask

  initial begin
    logic [7:0] v;
    int d0, c0;
    void'($urandom(32'h0BE5_1A7E));
    repeat (5) @(negedge clk);
    // R10
    chk(drv == 1'b0 && bvld == 1'b0, "R10 outputs in reset", int'({drv, bvld}), 0);
    rst_n = 1'b1;
    wait_us(20);
    chk(drv == 1'b0 && ncap == 0, "R10 idle after reset", drv_rises + ncap, 0);

    // R1 R2 R3: reset with long low period
    bus_reset(600);
    chk(drv_rises == 1, "R1 one presence", drv_rises, 1);
    // R9: own presence edges must not yield a byte
    chk(ncap == 0, "R9 no bits from presence", ncap, 0);

    // R4 R6 R7: directed patterns then random bytes
    write_byte(8'h01); expect_byte(8'h01, 0, "R6 lsb first");
    write_byte(8'h80); expect_byte(8'h80, 1, "R6 msb last");
    write_byte(8'hFF); expect_byte(8'hFF, 2, "R4 all ones");
    write_byte(8'h00); expect_byte(8'h00, 3, "R4 all zeros");
    for (int k = 0; k < 6; k++) begin
      v = 8'($urandom);
      write_byte(v);
      expect_byte(v, 4 + k, "R4 R7 random");
    end
    chk(drv_rises == 1, "R9 no extra presence", drv_rises, 1);

    // R5: 8th bit is a 479-tick low -> 0 bit, no reset
    d0 = drv_rises;
    for (int i = 0; i < 7; i++) write_bit(1'b1);
    m_low = 1'b1; wait_us(479); m_low = 1'b0;
    wait_us(200);
    expect_byte(lsb_first(8'h7F), 10, "R5 long zero");
    chk(drv_rises == d0, "R5 no presence", drv_rises, d0);

    // R8 R1: partial byte then reset at exactly 480
    write_bit(1'b1); write_bit(1'b1); write_bit(1'b1);
    c0 = ncap;
    bus_reset(480);
    chk(drv_rises == d0 + 1, "R1 reset at 480", drv_rises, d0 + 1);
    chk(ncap == c0, "R8 no byte from reset", ncap, c0);
    write_byte(8'h5A);
    expect_byte(8'h5A, 11, "R8 clean byte");

    // R9: byte right after a presence and random byte follows
    v = 8'($urandom);
    write_byte(v);
    expect_byte(v, 12, "R9 after presence");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule